// File: doc/BRIEF.md
# Write-Safe System Reset Sequencer

This block turns an asynchronous, active-low system reset request into an internal reset interval that runs on the fast oscillator. If the request arrives while the bus unit is part-way through a memory write, the reset is held back until that write is done. It then takes effect and lasts at least a fixed number of fast-oscillator cycles. If the request is still present when that minimum has elapsed, the reset continues until the request goes away.

While reset is in effect, the sequencer overrides several outputs. Every memory and I/O strobe is held at its inactive high level. Chip select 1 is released to high impedance, so a battery-backed RAM behind it can be kept deselected by a pull-up. Both clock dividers are forced to their slowest ratio. The block also provides the bus configuration and CPU register values that the rest of the chip loads at reset. It derives the length of an instruction fetch from the wait-state default and the current processor divider.

The real-time clock domain is not touched. Its flops take neither the sequencer's reset nor any of its outputs.

Top module: `wrsafe_rst_seq`

## Requirements
- R1: While `wr_busy_i` is high and `rst_o` is low, `rst_o` stays low on the next cycle. A write in progress defers the reset, and the reset starts on the first clock edge that sees `wr_busy_i` low.
- R2: With no write in progress, `rst_o` rises after the third rising clock edge that follows `sys_rst_ni` going low. Two of those edges are the synchronizer stages and one is the state register.
- R3: Every `rst_o` interval lasts at least `MIN_CYC` (128) cycles. If the request is withdrawn early, or while the sequencer is still waiting for a write, the interval is exactly 128 cycles.
- R4: `rst_o` falls only when the minimum count has expired and the synchronized request is deasserted. A request held longer extends the interval, and `rst_o` falls after the third rising edge that follows `sys_rst_ni` going high. On the cycle `rst_o` is low, the outputs pass the bus unit's values straight through.
- R5: While `rst_o` is high, all bits of `ctrl_n_o` are 1, `cs1_oe_o` is 0 (tri-stated) and `cs1_n_o` is 1.
- R6: While `rst_o` is high, `cpu_div_o` and `per_div_o` are both 3, where a code n means divide by 2^n. At other times they follow `cpu_div_i` and `per_div_i`.
- R7: The default outputs are as follows:
  - `dflt_wait_o` = 4 wait states.
  - `dflt_cs_sel_o` = 0 and `dflt_oe_sel_o` = 0, selecting chip select 0 and output enable 0.
  - `dflt_we_en_o` = 0, so writes are disabled.
  - `dflt_ip_o` = all ones.
  - `dflt_sp_o`, `dflt_pc_o`, `dflt_iir_o` and `dflt_eir_o` = zero.
- R8: `fetch_clks_o` equals 2^`cpu_div_o` × (2 + `dflt_wait_o`), which is 48 while `rst_o` is high.
- R9: After `rst_ni` is asserted, the sequencer begins with `rst_o` high and runs a full 128-cycle interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast oscillator clock |
| rst_ni | input | 1 | Power-on reset of the sequencer itself, active low, asynchronous |
| sys_rst_ni | input | 1 | System reset request, active low, asynchronous |
| wr_busy_i | input | 1 | Bus unit has a write cycle in progress |
| ctrl_n_i | input | N_CTRL | Memory/I/O strobes from the bus unit, active low |
| cs1_n_i | input | 1 | Chip select 1 level from the bus unit |
| cs1_oe_i | input | 1 | Chip select 1 output enable from the bus unit |
| cpu_div_i | input | 2 | Processor clock divider code, set by software |
| per_div_i | input | 2 | Peripheral clock divider code, set by software |
| ctrl_n_o | output | N_CTRL | Strobes to the pins |
| cs1_n_o | output | 1 | Chip select 1 level to the pin |
| cs1_oe_o | output | 1 | Chip select 1 pad output enable |
| cpu_div_o | output | 2 | Effective processor divider code |
| per_div_o | output | 2 | Effective peripheral divider code |
| rst_o | output | 1 | Internal reset and reset status, active high |
| fetch_clks_o | output | 8 | Fast clocks per fetch under the default wait states |
| dflt_wait_o | output | 4 | Default wait-state count |
| dflt_cs_sel_o | output | 2 | Default chip-select index |
| dflt_oe_sel_o | output | 2 | Default output-enable index |
| dflt_we_en_o | output | 1 | Default write enable |
| dflt_sp_o | output | 16 | Stack pointer reset value |
| dflt_pc_o | output | 16 | Program counter reset value |
| dflt_iir_o | output | 8 | Internal interrupt vector base reset value |
| dflt_eir_o | output | 8 | External interrupt vector base reset value |
| dflt_ip_o | output | 8 | Interrupt priority reset value |

## Verification
The reset request is tried in four directed patterns:
- A request that arrives with the bus idle measures the entry latency.
- A request made during a long write, and withdrawn before the write ends, tells deferral apart from the minimum interval.
- A request held well past 128 cycles tells the counter limit apart from the synchronized release.
- A power-on reset alone checks that the interval runs without any request.

Beyond these, a seeded random phase toggles the request, the write flag, the strobes and the divider codes independently. Each cycle is compared against a model built from the requirements, which brings out races such as a write starting in the same cycle that the synchronized request lands.

// File: rtl/wrsafe_rst_pkg.sv
package wrsafe_rst_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_WAIT_WR = 2'd1,
    ST_HOLD    = 2'd2
  } seq_st_e;

  localparam int unsigned DIV_W      = 2;
  localparam logic [DIV_W-1:0] DIV_SLOW = 2'd3;  // code n => divide by 2^n
  localparam int unsigned BASE_CLKS  = 2;        // bus cycle length without waits
endpackage

// File: rtl/wrsafe_rst_sync.sv
module wrsafe_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  // resets to 0: a request is seen as asserted until the pin is sampled
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= {q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/wrsafe_rst_fsm.sv
module wrsafe_rst_fsm
  import wrsafe_rst_pkg::*;
#(
  parameter int unsigned MIN_CYC = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,      // synchronized request, active high
  input  logic wr_busy_i,
  output logic in_rst_o
);
  localparam int unsigned CNT_W = (MIN_CYC > 1) ? $clog2(MIN_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_CYC - 1);

  seq_st_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_RUN: begin
        if (req_i) begin
          st_d  = wr_busy_i ? ST_WAIT_WR : ST_HOLD;
          cnt_d = '0;
        end
      end
      ST_WAIT_WR: begin
        // full minimum runs even if the request was already withdrawn
        if (!wr_busy_i) begin
          st_d  = ST_HOLD;
          cnt_d = '0;
        end
      end
      ST_HOLD: begin
        if (cnt_q == CNT_LAST) begin
          if (!req_i) st_d = ST_RUN;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        st_d  = ST_HOLD;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_HOLD;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign in_rst_o = (st_q == ST_HOLD);
endmodule

// File: rtl/wrsafe_rst_gate.sv
module wrsafe_rst_gate
  import wrsafe_rst_pkg::*;
#(
  parameter int unsigned N_CTRL = 6
) (
  input  logic              in_rst_i,
  input  logic [N_CTRL-1:0] ctrl_n_i,
  input  logic              cs1_n_i,
  input  logic              cs1_oe_i,
  input  logic [DIV_W-1:0]  cpu_div_i,
  input  logic [DIV_W-1:0]  per_div_i,
  output logic [N_CTRL-1:0] ctrl_n_o,
  output logic              cs1_n_o,
  output logic              cs1_oe_o,
  output logic [DIV_W-1:0]  cpu_div_o,
  output logic [DIV_W-1:0]  per_div_o
);
  genvar i;
  generate
    for (i = 0; i < N_CTRL; i++) begin : g_strb
      assign ctrl_n_o[i] = ctrl_n_i[i] | in_rst_i;
    end
  endgenerate

  // pad released; external pull-up keeps the RAM deselected
  assign cs1_oe_o  = cs1_oe_i & ~in_rst_i;
  assign cs1_n_o   = cs1_n_i | in_rst_i;
  assign cpu_div_o = in_rst_i ? DIV_SLOW : cpu_div_i;
  assign per_div_o = in_rst_i ? DIV_SLOW : per_div_i;
endmodule

// File: rtl/wrsafe_rst_dflt.sv
module wrsafe_rst_dflt
  import wrsafe_rst_pkg::*;
#(
  parameter int unsigned WAIT_W    = 4,
  parameter int unsigned WAIT_DFLT = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned FETCH_W   = 8
) (
  input  logic [DIV_W-1:0]   cpu_div_i,
  output logic [FETCH_W-1:0] fetch_clks_o,
  output logic [WAIT_W-1:0]  wait_o,
  output logic [SEL_W-1:0]   cs_sel_o,
  output logic [SEL_W-1:0]   oe_sel_o,
  output logic               we_en_o,
  output logic [ADDR_W-1:0]  sp_o,
  output logic [ADDR_W-1:0]  pc_o,
  output logic [VEC_W-1:0]   iir_o,
  output logic [VEC_W-1:0]   eir_o,
  output logic [VEC_W-1:0]   ip_o
);
  localparam logic [31:0] BUS_CLKS = 32'(BASE_CLKS + WAIT_DFLT);

  assign wait_o   = WAIT_W'(WAIT_DFLT);
  assign cs_sel_o = '0;
  assign oe_sel_o = '0;
  assign we_en_o  = 1'b0;
  assign sp_o     = '0;
  assign pc_o     = '0;
  assign iir_o    = '0;
  assign eir_o    = '0;
  assign ip_o     = '1;  // every interrupt level masked

  logic [31:0] fetch_full;
  assign fetch_full   = BUS_CLKS << cpu_div_i;
  assign fetch_clks_o = fetch_full[FETCH_W-1:0];
endmodule

// File: rtl/wrsafe_rst_seq.sv
module wrsafe_rst_seq
  import wrsafe_rst_pkg::*;
#(
  parameter int unsigned MIN_CYC   = 128,
  parameter int unsigned N_CTRL    = 6,
  parameter int unsigned SYNC_STG  = 2,
  parameter int unsigned WAIT_W    = 4,
  parameter int unsigned WAIT_DFLT = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned FETCH_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sys_rst_ni,
  input  logic               wr_busy_i,
  input  logic [N_CTRL-1:0]  ctrl_n_i,
  input  logic               cs1_n_i,
  input  logic               cs1_oe_i,
  input  logic [DIV_W-1:0]   cpu_div_i,
  input  logic [DIV_W-1:0]   per_div_i,
  output logic [N_CTRL-1:0]  ctrl_n_o,
  output logic               cs1_n_o,
  output logic               cs1_oe_o,
  output logic [DIV_W-1:0]   cpu_div_o,
  output logic [DIV_W-1:0]   per_div_o,
  output logic               rst_o,
  output logic [FETCH_W-1:0] fetch_clks_o,
  output logic [WAIT_W-1:0]  dflt_wait_o,
  output logic [SEL_W-1:0]   dflt_cs_sel_o,
  output logic [SEL_W-1:0]   dflt_oe_sel_o,
  output logic               dflt_we_en_o,
  output logic [ADDR_W-1:0]  dflt_sp_o,
  output logic [ADDR_W-1:0]  dflt_pc_o,
  output logic [VEC_W-1:0]   dflt_iir_o,
  output logic [VEC_W-1:0]   dflt_eir_o,
  output logic [VEC_W-1:0]   dflt_ip_o
);
  logic req_n_sync;
  logic in_rst;

  wrsafe_rst_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sys_rst_ni),
    .q_o    (req_n_sync)
  );

  wrsafe_rst_fsm #(.MIN_CYC(MIN_CYC)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (~req_n_sync),
    .wr_busy_i (wr_busy_i),
    .in_rst_o  (in_rst)
  );

  wrsafe_rst_gate #(.N_CTRL(N_CTRL)) u_gate (
    .in_rst_i  (in_rst),
    .ctrl_n_i  (ctrl_n_i),
    .cs1_n_i   (cs1_n_i),
    .cs1_oe_i  (cs1_oe_i),
    .cpu_div_i (cpu_div_i),
    .per_div_i (per_div_i),
    .ctrl_n_o  (ctrl_n_o),
    .cs1_n_o   (cs1_n_o),
    .cs1_oe_o  (cs1_oe_o),
    .cpu_div_o (cpu_div_o),
    .per_div_o (per_div_o)
  );

  wrsafe_rst_dflt #(
    .WAIT_W(WAIT_W), .WAIT_DFLT(WAIT_DFLT), .ADDR_W(ADDR_W),
    .VEC_W(VEC_W), .SEL_W(SEL_W), .FETCH_W(FETCH_W)
  ) u_dflt (
    .cpu_div_i    (cpu_div_o),
    .fetch_clks_o (fetch_clks_o),
    .wait_o       (dflt_wait_o),
    .cs_sel_o     (dflt_cs_sel_o),
    .oe_sel_o     (dflt_oe_sel_o),
    .we_en_o      (dflt_we_en_o),
    .sp_o         (dflt_sp_o),
    .pc_o         (dflt_pc_o),
    .iir_o        (dflt_iir_o),
    .eir_o        (dflt_eir_o),
    .ip_o         (dflt_ip_o)
  );

  assign rst_o = in_rst;
endmodule

// File: rtl/wrsafe_rst_chk.sv
module wrsafe_rst_chk #(
  parameter int unsigned MIN_CYC = 128,
  parameter int unsigned N_CTRL  = 6,
  parameter int unsigned DIV_W   = 2,
  parameter int unsigned FETCH_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_busy_i,
  input logic               rst_o,
  input logic [N_CTRL-1:0]  ctrl_n_o,
  input logic               cs1_n_o,
  input logic               cs1_oe_o,
  input logic [DIV_W-1:0]   cpu_div_o,
  input logic [DIV_W-1:0]   per_div_o,
  input logic [FETCH_W-1:0] fetch_clks_o
);
  localparam int unsigned LEN_W = $clog2(MIN_CYC + 1) + 1;

  logic [LEN_W-1:0] len_q;
  logic             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      prev_q <= 1'b1;
    end else begin
      prev_q <= rst_o;
      if (!rst_o)                          len_q <= '0;
      else if (len_q < LEN_W'(MIN_CYC))    len_q <= len_q + 1'b1;
    end
  end

  a_r1_write_defers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_busy_i && !rst_o) |=> !rst_o);

  // R3 and R9: interval length counted here rather than with a deep $past
  a_r3_min_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_q && !rst_o) |-> (len_q >= LEN_W'(MIN_CYC)));

  a_r5_strobes_safe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o |-> ((&ctrl_n_o) && cs1_n_o && !cs1_oe_o));

  a_r6_div_slow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o |-> ((cpu_div_o == DIV_W'(3)) && (per_div_o == DIV_W'(3))));

  a_r8_fetch_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o |-> (fetch_clks_o == FETCH_W'(48)));
endmodule

bind wrsafe_rst_seq wrsafe_rst_chk #(
  .MIN_CYC(MIN_CYC), .N_CTRL(N_CTRL), .DIV_W(2), .FETCH_W(FETCH_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_busy_i    (wr_busy_i),
  .rst_o        (rst_o),
  .ctrl_n_o     (ctrl_n_o),
  .cs1_n_o      (cs1_n_o),
  .cs1_oe_o     (cs1_oe_o),
  .cpu_div_o    (cpu_div_o),
  .per_div_o    (per_div_o),
  .fetch_clks_o (fetch_clks_o)
);

// File: tb/wrsafe_rst_seq_test.sv
`timescale 1ns/1ps
module wrsafe_rst_seq_test;
  localparam int NC = 6;
  localparam int MINC = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_n = 1'b1;
  logic busy = 1'b0;
  logic [NC-1:0] ctrl_i = '0;
  logic cs1_i = 1'b0, cs1oe_i = 1'b1;
  logic [1:0] cdiv_i = 2'd0, pdiv_i = 2'd1;

  logic [NC-1:0] ctrl_o;
  logic cs1_o, cs1oe_o, rst_o, we_en;
  logic [1:0] cdiv_o, pdiv_o, cs_sel, oe_sel;
  logic [7:0] fetch, iir, eir, ip;
  logic [3:0] wt;
  logic [15:0] sp, pc;

  int n_run = 0, n_fail = 0;
  bit cmp_en = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  wrsafe_rst_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .sys_rst_ni(sys_n), .wr_busy_i(busy),
    .ctrl_n_i(ctrl_i), .cs1_n_i(cs1_i), .cs1_oe_i(cs1oe_i),
    .cpu_div_i(cdiv_i), .per_div_i(pdiv_i),
    .ctrl_n_o(ctrl_o), .cs1_n_o(cs1_o), .cs1_oe_o(cs1oe_o),
    .cpu_div_o(cdiv_o), .per_div_o(pdiv_o), .rst_o(rst_o),
    .fetch_clks_o(fetch), .dflt_wait_o(wt), .dflt_cs_sel_o(cs_sel),
    .dflt_oe_sel_o(oe_sel), .dflt_we_en_o(we_en), .dflt_sp_o(sp),
    .dflt_pc_o(pc), .dflt_iir_o(iir), .dflt_eir_o(eir), .dflt_ip_o(ip)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // requirement model: sync pipeline, deferral, minimum count
  logic m_s1, m_s2;
  int   m_mode;  // 0 run, 1 waiting for write, 2 holding reset
  int   m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 1'b0; m_s2 <= 1'b0; m_mode <= 2; m_cnt <= 0;
    end else begin
      m_s1 <= sys_n; m_s2 <= m_s1;
      case (m_mode)
        0: if (!m_s2) begin m_mode <= busy ? 1 : 2; m_cnt <= 0; end
        1: if (!busy) begin m_mode <= 2; m_cnt <= 0; end
        default: if (m_cnt == MINC-1) begin if (m_s2) m_mode <= 0; end
                 else m_cnt <= m_cnt + 1;
      endcase
    end
  end

  function automatic int exp_fetch(input logic [1:0] d);
    return (1 << d) * (2 + 4);
  endfunction

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      bit r;
      logic [1:0] ecd, epd;
      r = (m_mode == 2);
      ecd = r ? 2'd3 : cdiv_i;
      epd = r ? 2'd3 : pdiv_i;
      chk(rst_o == r, "R1/R2/R4 rst_o vs model", rst_o, r);
      chk(ctrl_o == (r ? {NC{1'b1}} : ctrl_i), "R5 ctrl_n_o", ctrl_o, r ? (1<<NC)-1 : ctrl_i);
      chk(cs1oe_o == (r ? 1'b0 : cs1oe_i), "R5 cs1_oe_o", cs1oe_o, r ? 0 : cs1oe_i);
      chk(cs1_o == (r ? 1'b1 : cs1_i), "R5 cs1_n_o", cs1_o, r ? 1 : cs1_i);
      chk(cdiv_o == ecd && pdiv_o == epd, "R6 divider codes", {cdiv_o, pdiv_o}, {ecd, epd});
      chk(fetch == 8'(exp_fetch(ecd)), "R8 fetch_clks_o", fetch, exp_fetch(ecd));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic meas_high(output int len);
    len = 0;
    while (rst_o && len < 5000) begin tick(1); len++; end
  endtask

  initial begin
    int cnt, len;
    void'($urandom(32'h5eed_0042));
    #9; rst_n = 1'b1;          // between edges
    @(posedge clk); #1;
    cmp_en = 1'b1;
    // R9: power-on runs a full interval
    chk(rst_o == 1'b1, "R9 rst_o after power-on", rst_o, 1);
    meas_high(len);
    chk(len == MINC - 1, "R9 power-on length", len + 1, MINC);
    // R7 defaults
    chk(wt == 4, "R7 wait states", wt, 4);
    chk(cs_sel == 0 && oe_sel == 0, "R7 cs/oe select", {cs_sel, oe_sel}, 0);
    chk(we_en == 1'b0, "R7 write enable", we_en, 0);
    chk(ip == 8'hff, "R7 interrupt priority", ip, 255);
    chk(sp == 0 && pc == 0 && iir == 0 && eir == 0, "R7 zero registers",
        int'(sp) + int'(pc) + int'(iir) + int'(eir), 0);
    tick(5);

    // R2: idle bus, latency three edges
    sys_n = 1'b0;
    cnt = 0;
    while (!rst_o && cnt < 20) begin tick(1); cnt++; end
    chk(cnt == 3, "R2 entry latency", cnt, 3);
    sys_n = 1'b1;
    meas_high(len);
    chk(len == MINC, "R3 early release length", len, MINC);
    tick(4);

    // R1: write in progress defers, early withdrawal still gives full minimum
    busy = 1'b1; sys_n = 1'b0;
    tick(6);
    sys_n = 1'b1;
    tick(20);
    chk(rst_o == 1'b0, "R1 deferred during write", rst_o, 0);
    busy = 1'b0;
    tick(1);
    chk(rst_o == 1'b1, "R1 entry after write ends", rst_o, 1);
    meas_high(len);
    chk(len == MINC, "R3 length after deferral", len, MINC);
    tick(4);

    // R4: held request extends the interval
    sys_n = 1'b0;
    tick(300);
    sys_n = 1'b1;
    cnt = 0;
    while (rst_o && cnt < 20) begin tick(1); cnt++; end
    chk(cnt == 3, "R4 release latency", cnt, 3);
    chk(ctrl_o == ctrl_i, "R4 passthrough on release", ctrl_o, ctrl_i);
    tick(4);

    // random phase, compared every cycle against the model
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 149) == 0) sys_n = ~sys_n;
      if ($urandom_range(0, 3) == 0) busy = ~busy;
      ctrl_i = NC'($urandom);
      cs1_i = 1'($urandom); cs1oe_i = 1'($urandom);
      cdiv_i = 2'($urandom); pdiv_i = 2'($urandom);
      tick(1);
    end
    sys_n = 1'b1; busy = 1'b0;
    tick(400);
    chk(rst_o == 1'b0, "R4 idle at end", rst_o, 0);
    cmp_en = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule